// File: doc/BRIEF.md
# Packet Page Pool Manager

This block owns a small pool of fixed-size packet pages and tracks who holds each one. A bitmask records which pages are taken. Three shift-register queues of page numbers hold the receive queue, the transmit queue and the transmit-done queue. A host drives 8-bit command bytes that allocate, release, enqueue and flush pages. A receive path asks for pages directly. When transmission is enabled, the queued transmit pages either go back to the pool or move on to the done queue.

A transmit allocation that finds the pool full does not fail for good. The result register holds the "no page" code, and the request is served automatically by the next page that gets freed. The block raises its allocation interrupt at that moment. All state changes take effect on one clock edge.

Within a cycle the sources have a fixed priority. A receive request comes first. Otherwise a host command runs. If neither is present, the cycle is idle: a done-queue pop and the transmit drain may then occur.

Top module: `page_pool_mmu`

## Requirements
- R1: The command field is bits 7:5 of `cmd_byte`. Code 1 allocates for transmit: it clears `alloc_irq`, then takes the lowest-numbered free page, sets its mask bit, writes the page number into `alloc_result` and sets `alloc_irq`. If no page is free, `alloc_result` becomes 8'h80 and `alloc_irq` stays clear.
- R2: Reset, and command code 2, clear the page mask and empty all three queues. Both set `alloc_result` to 8'h00. Command code 2 leaves `alloc_irq` unchanged; reset clears it.
- R3: While `alloc_result` is 8'h80, every page release re-runs the pending allocation at once. The release makes the lowest free page available, that page is taken, and `alloc_irq` is set.
- R4: A receive request is granted (`rx_grant` high in the same cycle) when a page is free. The grant takes the lowest free page, reports it on `rx_page` and appends it to the receive queue. When all pages are taken the request is refused and changes nothing. A host command in the same cycle as a receive request is discarded.
- R5: Command code 3 pops the receive queue. Code 4 first releases the receive head page, then pops. Both do nothing when the queue is empty. `rx_head` shows the head page, or 8'h80 when the queue is empty.
- R6: Command code 5 releases the page given on `pkt_num`.
- R7: Command code 6 appends `pkt_num` to the transmit queue, and does nothing if the queue already holds `Q_DEPTH` entries. While `tx_enable` is low, the transmit queue never drains.
- R8: In an idle cycle with `tx_enable` high, every transmit entry is handled head first, and the transmit queue is then empty. When `auto_release` is high, each page is released. Otherwise each page is appended to the done queue while that queue has room.
- R9: `done_head` shows the done-queue head, or 8'h80 when the queue is empty. `done_pop` in an idle cycle removes the head before the drain appends. Command code 7 empties both the transmit queue and the done queue. Code 0 does nothing.
- R10: `used_pages` equals the number of set bits in `page_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command byte present this cycle |
| cmd_byte | input | 8 | Host command; bits 7:5 select the operation |
| pkt_num | input | 2 | Page number used by release and enqueue commands |
| tx_enable | input | 1 | Allows the transmit queue to drain |
| auto_release | input | 1 | Drained pages go back to the pool instead of the done queue |
| done_pop | input | 1 | Remove the done-queue head (idle cycles) |
| rx_req | input | 1 | Receive path asks for a page |
| rx_grant | output | 1 | Receive request granted this cycle |
| rx_page | output | 2 | Page granted to the receive path |
| alloc_result | output | 8 | Last transmit allocation result, 8'h80 = pending |
| alloc_irq | output | 1 | Allocation-complete interrupt level |
| page_mask | output | 4 | One bit per allocated page |
| used_pages | output | 3 | Number of allocated pages |
| rx_count | output | 3 | Receive queue occupancy |
| tx_count | output | 3 | Transmit queue occupancy |
| done_count | output | 3 | Done queue occupancy |
| rx_head | output | 8 | Receive queue head, 8'h80 when empty |
| done_head | output | 8 | Done queue head, 8'h80 when empty |

## Verification
The bench builds the block with its default four pages and queues four entries deep. With those values the pool empties after four allocations, and the transmit queue fills after four enqueues. A failed allocation is left pending, so the retry on a later release can be shown. A receive refusal, the ignored fifth enqueue and a drain under both release policies each take only a few cycles to reach. A behavioural model with dynamic queues predicts every output on every cycle.

// File: rtl/page_pool_pkg.sv
package page_pool_pkg;

    typedef enum logic [2:0] {
        PC_NOP       = 3'd0,
        PC_ALLOC_TX  = 3'd1,
        PC_RESET     = 3'd2,
        PC_RX_POP    = 3'd3,
        PC_RX_FREE   = 3'd4,
        PC_FREE_PNUM = 3'd5,
        PC_TX_PUSH   = 3'd6,
        PC_TX_FLUSH  = 3'd7
    } pool_cmd_e;

    localparam logic [7:0] NO_PAGE = 8'h80;

    typedef struct packed {
        logic clr;
        logic pop;
    } q_ctl_t;

    function automatic pool_cmd_e decode_cmd(input logic [7:0] b);
        return pool_cmd_e'(b[7:5]);
    endfunction

endpackage

// File: rtl/pp_pick.sv
module pp_pick #(
    parameter int N  = 4,
    parameter int PW = 2,
    parameter int UW = 3
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [PW-1:0] idx,
    output logic [UW-1:0] used
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!mask[i]) begin
                found = 1'b1;
                idx   = PW'(i);
            end
        end
    end

    always_comb begin
        used = '0;
        for (int i = 0; i < N; i++) begin
            used = used + UW'(mask[i]);
        end
    end
endmodule

// File: rtl/pp_queue.sv
module pp_queue
    import page_pool_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PW    = 2,
    parameter int CW    = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  q_ctl_t                    ctl,
    input  logic [CW-1:0]             push_n,
    input  logic [DEPTH-1:0][PW-1:0]  push_data,
    output logic [DEPTH-1:0][PW-1:0]  ent,
    output logic [CW-1:0]             count
);
    logic [DEPTH-1:0][PW-1:0] ent_q, ent_n;
    logic [CW-1:0]            cnt_q, cnt_n;

    always_comb begin
        ent_n = ent_q;
        cnt_n = cnt_q;
        if (ctl.clr) cnt_n = '0;
        if (ctl.pop && cnt_n != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) ent_n[i] = ent_n[i+1];
            cnt_n = cnt_n - 1'b1;
        end
        for (int k = 0; k < DEPTH; k++) begin
            if (CW'(k) < push_n && cnt_n < CW'(DEPTH)) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (CW'(j) == cnt_n) ent_n[j] = push_data[k];
                end
                cnt_n = cnt_n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
            cnt_q <= '0;
        end else begin
            ent_q <= ent_n;
            cnt_q <= cnt_n;
        end
    end

    assign ent   = ent_q;
    assign count = cnt_q;

    AST_Q_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH)); // R7
endmodule

// File: rtl/page_pool_mmu.sv
module page_pool_mmu
    import page_pool_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int Q_DEPTH   = 4,
    localparam int PW = $clog2(NUM_PAGES),
    localparam int CW = $clog2(Q_DEPTH + 1),
    localparam int UW = $clog2(NUM_PAGES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_byte,
    input  logic [PW-1:0]        pkt_num,
    input  logic                 tx_enable,
    input  logic                 auto_release,
    input  logic                 done_pop,
    input  logic                 rx_req,
    output logic                 rx_grant,
    output logic [PW-1:0]        rx_page,
    output logic [7:0]           alloc_result,
    output logic                 alloc_irq,
    output logic [NUM_PAGES-1:0] page_mask,
    output logic [UW-1:0]        used_pages,
    output logic [CW-1:0]        rx_count,
    output logic [CW-1:0]        tx_count,
    output logic [CW-1:0]        done_count,
    output logic [7:0]           rx_head,
    output logic [7:0]           done_head
);
    typedef struct packed {
        logic [NUM_PAGES-1:0] mask;
        logic [7:0]           res;
        logic                 irq;
    } pool_st_t;

    function automatic pool_st_t free_page(input pool_st_t s, input logic [PW-1:0] pg);
        pool_st_t o;
        logic     hit;
        int       lo;
        o = s;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (PW'(i) == pg) o.mask[i] = 1'b0;
        end
        if (o.res == NO_PAGE) begin
            hit = 1'b0;
            lo  = 0;
            for (int i = NUM_PAGES - 1; i >= 0; i--) begin
                if (!o.mask[i]) begin
                    hit = 1'b1;
                    lo  = i;
                end
            end
            if (hit) begin
                o.mask[lo] = 1'b1;
                o.res      = 8'(lo);
                o.irq      = 1'b1;
            end
        end
        return o;
    endfunction

    pool_st_t cur_q, nxt;
    pool_cmd_e cmd;

    logic                      pk_found;
    logic [PW-1:0]             pk_idx;

    q_ctl_t                    rx_ctl, tx_ctl, dn_ctl;
    logic [CW-1:0]             rx_pn, tx_pn, dn_pn;
    logic [Q_DEPTH-1:0][PW-1:0] rx_pd, tx_pd, dn_pd;
    logic [Q_DEPTH-1:0][PW-1:0] rx_ent, tx_ent, dn_ent;
    logic [CW-1:0]             rx_cnt, tx_cnt, dn_cnt;
    logic [CW-1:0]             dn_base;

    assign cmd = decode_cmd(cmd_byte);

    pp_pick #(.N(NUM_PAGES), .PW(PW), .UW(UW)) u_pick (
        .mask  (cur_q.mask),
        .found (pk_found),
        .idx   (pk_idx),
        .used  (used_pages)
    );

    assign rx_grant = rx_req && pk_found && (rx_cnt < CW'(Q_DEPTH));
    assign rx_page  = pk_idx;

    always_comb begin
        nxt    = cur_q;
        rx_ctl = '0; tx_ctl = '0; dn_ctl = '0;
        rx_pn  = '0; tx_pn  = '0; dn_pn  = '0;
        rx_pd  = '0; tx_pd  = '0; dn_pd  = '0;
        dn_base = dn_cnt;
        if (rx_req) begin
            if (rx_grant) begin
                nxt.mask[pk_idx] = 1'b1;
                rx_pn    = CW'(1);
                rx_pd[0] = pk_idx;
            end
        end else if (cmd_valid) begin
            unique case (cmd)
                PC_NOP: ;
                PC_ALLOC_TX: begin
                    nxt.irq = 1'b0;
                    if (pk_found) begin
                        nxt.mask[pk_idx] = 1'b1;
                        nxt.res = 8'(pk_idx);
                        nxt.irq = 1'b1;
                    end else begin
                        nxt.res = NO_PAGE;
                    end
                end
                PC_RESET: begin
                    nxt.mask   = '0;
                    nxt.res    = 8'h00;
                    rx_ctl.clr = 1'b1;
                    tx_ctl.clr = 1'b1;
                    dn_ctl.clr = 1'b1;
                end
                PC_RX_POP: rx_ctl.pop = 1'b1;
                PC_RX_FREE: begin
                    if (rx_cnt != '0) nxt = free_page(nxt, rx_ent[0]);
                    rx_ctl.pop = 1'b1;
                end
                PC_FREE_PNUM: nxt = free_page(nxt, pkt_num);
                PC_TX_PUSH: begin
                    tx_pn    = CW'(1);
                    tx_pd[0] = pkt_num;
                end
                PC_TX_FLUSH: begin
                    tx_ctl.clr = 1'b1;
                    dn_ctl.clr = 1'b1;
                end
                default: ;
            endcase
        end else begin
            if (done_pop && dn_cnt != '0) begin
                dn_ctl.pop = 1'b1;
                dn_base    = dn_cnt - 1'b1;
            end
            if (tx_enable && tx_cnt != '0) begin
                tx_ctl.clr = 1'b1;
                for (int i = 0; i < Q_DEPTH; i++) begin
                    if (CW'(i) < tx_cnt) begin
                        if (auto_release) begin
                            nxt = free_page(nxt, tx_ent[i]);
                        end else if ((dn_base + dn_pn) < CW'(Q_DEPTH)) begin
                            for (int j = 0; j < Q_DEPTH; j++) begin
                                if (CW'(j) == dn_pn) dn_pd[j] = tx_ent[i];
                            end
                            dn_pn = dn_pn + 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.mask <= '0;
            cur_q.res  <= 8'h00;
            cur_q.irq  <= 1'b0;
        end else begin
            cur_q <= nxt;
        end
    end

    pp_queue #(.DEPTH(Q_DEPTH), .PW(PW), .CW(CW)) u_rxq (
        .clk(clk), .rst(rst), .ctl(rx_ctl), .push_n(rx_pn), .push_data(rx_pd),
        .ent(rx_ent), .count(rx_cnt)
    );
    pp_queue #(.DEPTH(Q_DEPTH), .PW(PW), .CW(CW)) u_txq (
        .clk(clk), .rst(rst), .ctl(tx_ctl), .push_n(tx_pn), .push_data(tx_pd),
        .ent(tx_ent), .count(tx_cnt)
    );
    pp_queue #(.DEPTH(Q_DEPTH), .PW(PW), .CW(CW)) u_dnq (
        .clk(clk), .rst(rst), .ctl(dn_ctl), .push_n(dn_pn), .push_data(dn_pd),
        .ent(dn_ent), .count(dn_cnt)
    );

    assign alloc_result = cur_q.res;
    assign alloc_irq    = cur_q.irq;
    assign page_mask    = cur_q.mask;
    assign rx_count     = rx_cnt;
    assign tx_count     = tx_cnt;
    assign done_count   = dn_cnt;
    assign rx_head      = (rx_cnt == '0) ? NO_PAGE : 8'(rx_ent[0]);
    assign done_head    = (dn_cnt == '0) ? NO_PAGE : 8'(dn_ent[0]);

    AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
        alloc_result == NO_PAGE || alloc_result < 8'(NUM_PAGES)); // R1
    AST_FULL_ALLOC_PENDS: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !rx_req && cmd == PC_ALLOC_TX && (&page_mask)
        |=> alloc_result == NO_PAGE && !alloc_irq); // R1
    AST_RETRY_ON_FREE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !rx_req && cmd == PC_FREE_PNUM && alloc_result == NO_PAGE
        |=> alloc_result != NO_PAGE && alloc_irq); // R3
    AST_RX_REFUSED: assert property (@(posedge clk) disable iff (rst)
        rx_req && (&page_mask)
        |=> page_mask == $past(page_mask) && rx_count == $past(rx_count)); // R4
    AST_TX_HELD: assert property (@(posedge clk) disable iff (rst)
        !tx_enable && !cmd_valid && !rx_req |=> tx_count == $past(tx_count)); // R7
    AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        tx_enable && !cmd_valid && !rx_req |=> tx_count == '0); // R8
endmodule

// File: tb/tb_page_pool_mmu.sv
module tb_page_pool_mmu;
    localparam int NP = 4;
    localparam int QD = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [7:0] cmd_byte;
    logic [1:0] pkt_num;
    logic       tx_enable, auto_release, done_pop, rx_req;
    logic       rx_grant;
    logic [1:0] rx_page;
    logic [7:0] alloc_result;
    logic       alloc_irq;
    logic [3:0] page_mask;
    logic [2:0] used_pages, rx_count, tx_count, done_count;
    logic [7:0] rx_head, done_head;

    page_pool_mmu #(.NUM_PAGES(NP), .Q_DEPTH(QD)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .pkt_num(pkt_num), .tx_enable(tx_enable), .auto_release(auto_release),
        .done_pop(done_pop), .rx_req(rx_req), .rx_grant(rx_grant), .rx_page(rx_page),
        .alloc_result(alloc_result), .alloc_irq(alloc_irq), .page_mask(page_mask),
        .used_pages(used_pages), .rx_count(rx_count), .tx_count(tx_count),
        .done_count(done_count), .rx_head(rx_head), .done_head(done_head)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;

    int m_mask, m_res, m_irq;
    int m_rxq[$];
    int m_txq[$];
    int m_dq[$];

    function automatic int lowest_free();
        for (int i = 0; i < NP; i++) if (((m_mask >> i) & 1) == 0) return i;
        return -1;
    endfunction

    function automatic int pop_count();
        int n = 0;
        for (int i = 0; i < NP; i++) n += (m_mask >> i) & 1;
        return n;
    endfunction

    function automatic void m_free(int p);
        int lo;
        m_mask &= ~(1 << p);
        if (m_res == 128) begin
            lo = lowest_free();
            if (lo >= 0) begin
                m_mask |= (1 << lo);
                m_res = lo;
                m_irq = 1;
            end
        end
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit cv, logic [7:0] cb, int pn,
                        bit txe, bit ar, bit dp, bit rxr);
        int  lo;
        bit  exp_grant;
        @(negedge clk);
        cmd_valid = cv; cmd_byte = cb; pkt_num = pn[1:0];
        tx_enable = txe; auto_release = ar; done_pop = dp; rx_req = rxr;
        #1;
        lo = lowest_free();
        exp_grant = rxr && lo >= 0 && m_rxq.size() < QD;
        chk(tag, "alloc_result", alloc_result, m_res);
        chk(tag, "alloc_irq", alloc_irq, m_irq);
        chk(tag, "page_mask", page_mask, m_mask);
        chk("R10", "used_pages", used_pages, pop_count());
        chk(tag, "rx_count", rx_count, m_rxq.size());
        chk(tag, "tx_count", tx_count, m_txq.size());
        chk(tag, "done_count", done_count, m_dq.size());
        chk(tag, "rx_head", rx_head, m_rxq.size() == 0 ? 128 : m_rxq[0]);
        chk(tag, "done_head", done_head, m_dq.size() == 0 ? 128 : m_dq[0]);
        chk(tag, "rx_grant", rx_grant, exp_grant);
        if (exp_grant) chk(tag, "rx_page", rx_page, lo);
        @(posedge clk);
        if (rxr) begin
            if (exp_grant) begin
                m_mask |= (1 << lo);
                m_rxq.push_back(lo);
            end
        end else if (cv) begin
            case (cb[7:5])
                3'd1: begin
                    m_irq = 0;
                    if (lo >= 0) begin m_mask |= (1 << lo); m_res = lo; m_irq = 1; end
                    else m_res = 128;
                end
                3'd2: begin
                    m_mask = 0; m_res = 0;
                    m_rxq.delete(); m_txq.delete(); m_dq.delete();
                end
                3'd3: if (m_rxq.size() > 0) void'(m_rxq.pop_front());
                3'd4: if (m_rxq.size() > 0) begin m_free(m_rxq[0]); void'(m_rxq.pop_front()); end
                3'd5: m_free(pn);
                3'd6: if (m_txq.size() < QD) m_txq.push_back(pn);
                3'd7: begin m_txq.delete(); m_dq.delete(); end
                default: ;
            endcase
        end else begin
            if (dp && m_dq.size() > 0) void'(m_dq.pop_front());
            if (txe && m_txq.size() > 0) begin
                foreach (m_txq[i]) begin
                    if (ar) m_free(m_txq[i]);
                    else if (m_dq.size() < QD) m_dq.push_back(m_txq[i]);
                end
                m_txq.delete();
            end
        end
    endtask

    task automatic cmd(string tag, logic [7:0] cb, int pn = 0);
        step(tag, 1'b1, cb, pn, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle(string tag, bit txe = 0, bit ar = 0, bit dp = 0);
        step(tag, 1'b0, 8'h00, 0, txe, ar, dp, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmd_valid = 0; cmd_byte = 0; pkt_num = 0;
        tx_enable = 0; auto_release = 0; done_pop = 0; rx_req = 0;
        m_mask = 0; m_res = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R2");                       // reset state
        // R1: four allocations take pages 0..3, low bits of the byte ignored
        cmd("R1", 8'h20);
        cmd("R1", 8'h3F);
        cmd("R1", 8'h25);
        cmd("R1", 8'h20);
        cmd("R1", 8'h20);                 // pool full -> 0x80, irq clear
        idle("R1");
        // R3 / R6: releasing page 2 serves the pending allocation
        cmd("R6", 8'hA0, 2);
        idle("R3");
        // R7: four enqueues, fifth ignored, no drain while disabled
        cmd("R7", 8'hC0, 0);
        cmd("R7", 8'hC0, 1);
        cmd("R7", 8'hC0, 2);
        cmd("R7", 8'hC0, 3);
        cmd("R7", 8'hC0, 0);
        idle("R7");
        idle("R7");
        // R8: drain into done queue
        idle("R8", 1'b1, 1'b0);
        idle("R8");
        // R9: pop done head twice, nop command, then flush
        idle("R9", 1'b0, 1'b0, 1'b1);
        idle("R9", 1'b0, 1'b0, 1'b1);
        cmd("R9", 8'h00);
        cmd("R9", 8'hE0);
        idle("R9");
        // R4: refused when full, then granted; command in same cycle dropped
        step("R4", 1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        cmd("R6", 8'hA0, 1);
        cmd("R6", 8'hA0, 3);
        step("R4", 1'b1, 8'h20, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        step("R4", 1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        idle("R4");
        // R5: free-and-pop, pop, pop on empty
        cmd("R5", 8'h80);
        cmd("R5", 8'h60);
        cmd("R5", 8'h60);
        cmd("R5", 8'h80);
        idle("R5");
        // R2: MMU reset command, irq kept
        cmd("R2", 8'h40);
        idle("R2");
        // R3 / R8: pending allocation served by auto-release drain
        cmd("R1", 8'h20);
        cmd("R1", 8'h20);
        cmd("R1", 8'h20);
        cmd("R1", 8'h20);
        cmd("R1", 8'h20);
        cmd("R7", 8'hC0, 3);
        cmd("R7", 8'hC0, 1);
        idle("R8", 1'b1, 1'b1);
        idle("R3");
        // R8: done queue keeps room limit while draining, done_pop with drain
        cmd("R7", 8'hC0, 1);
        idle("R8", 1'b1, 1'b0);
        cmd("R7", 8'hC0, 0);
        cmd("R7", 8'hC0, 2);
        idle("R8", 1'b1, 1'b0, 1'b1);
        idle("R9", 1'b0, 1'b0, 1'b1);
        idle("R10");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule